// File: doc/BRIEF.md
# Sleep-State Power Sequencer

This controller turns two active-low system sleep requests into the enables that bring a memory supply through run, suspend and shutdown. It drives a switching regulator for the core rail and a standby linear regulator that holds the core rail during suspend. It also drives a linear regulator for the termination rail, a pull-low control for a switch that blocks current flowing back into the input rail, and a power-good output. The analog side reports back through comparator flags that are already synchronized: standby bias above its power-on threshold, 12 V bias above its power-on threshold, blocking-switch gate node above its trip level, and termination rail inside its window. A separate level input disables every regulator while a fault is present.

A cold start runs two timed phases of `PHASE_LEN` switching-clock cycles each. In the first the error amplifier is held in reset. In the second a digital soft-start ramp code climbs to full scale. A resume from suspend takes a shorter path. It re-enables the regulators at once, but keeps the power-good comparator disabled for one `PHASE_LEN` window. All outputs are registered.

Top module: `sleep_seq_ctrl`

## Requirements
- R1: Both sleep inputs pass through a two-flop synchronizer. A level change on a sleep input shows on the outputs at the third rising clock edge after it. Decode: both inputs high means run. `slp_susp_n` low with `slp_off_n` high means suspend. `slp_off_n` low means shutdown, whatever the level of `slp_susp_n`.
- R2: After reset, and after any shutdown, a suspend request is ignored until the run state has been reached. A suspend request that arrives during the two cold-start phases is also ignored.
- R3: A cold start begins only when the decoded request is run, `sby_por_ok`, `v12_por_ok` and `blk_trip_ok` are all 1, and `fault_off` is 0.
- R4: A cold start first asserts `amp_reset` for exactly `PHASE_LEN` cycles. During that time `core_en` and `term_en` are 1, `sby_en` is 0 and `blk_drive_low` is 0.
- R5: The ramp phase then follows for exactly `PHASE_LEN` cycles with `ss_active` at 1. In ramp cycle i (counting from 0), `ramp_code` is i·2^RAMP_W/PHASE_LEN. `ramp_code` is all ones in run, suspend and resume, and 0 otherwise.
- R6: Entering suspend sets `sby_en` to 1 and `core_en`, `term_en`, `pwr_ok` and `pg_cmp_en` to 0 in the same edge. It also sets `blk_drive_low` to 1.
- R7: A run request in suspend starts a resume only while `v12_por_ok` is 1. Resume sets `core_en` and `term_en` to 1, `sby_en` to 0 and `blk_drive_low` to 0. `pg_cmp_en` stays 0 for `PHASE_LEN` cycles, then the run state is entered. A suspend request during resume returns to suspend.
- R8: A shutdown request from any state clears every enable, `ramp_code` and `pwr_ok`, and sets `blk_drive_low` to 1.
- R9: `pwr_ok` is 0 outside the run state. In run it equals `term_win_ok` sampled at the previous rising edge.
- R10: `fault_off` at 1 sends the block to the shutdown state at the next edge, with the R8 outputs. A fault or a shutdown request takes priority over every other transition, including a phase expiring in the same cycle.
- R11: `ref_short` is 1 whenever `term_en` is 0, and 0 whenever `term_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst | input | 1 | Synchronous active-high reset |
| slp_susp_n | input | 1 | Active-low suspend request, asynchronous |
| slp_off_n | input | 1 | Active-low shutdown request, asynchronous |
| sby_por_ok | input | 1 | Standby bias above power-on threshold |
| v12_por_ok | input | 1 | 12 V bias above power-on threshold |
| blk_trip_ok | input | 1 | Blocking-switch gate node above trip level |
| term_win_ok | input | 1 | Termination rail within its window |
| fault_off | input | 1 | Fault disable, level sensitive |
| core_en | output | 1 | Switching core-rail regulator enable |
| sby_en | output | 1 | Standby linear regulator enable |
| term_en | output | 1 | Termination regulator enable |
| ref_short | output | 1 | Short termination reference to its output |
| blk_drive_low | output | 1 | 1 pulls blocking-switch control low, 0 releases it |
| amp_reset | output | 1 | Error-amplifier reset strobe |
| ss_active | output | 1 | Digital soft-start ramp running |
| ramp_code | output | RAMP_W | Soft-start ramp code |
| pg_cmp_en | output | 1 | Power-good comparator enable |
| pwr_ok | output | 1 | Power good |

## Verification
Two events can fall in the same cycle: a timed phase reaching its last count, and a decoded sleep request (or a fault) that calls for a different state. The bench provokes this by releasing a suspend request at offsets around the end of the resume window, and by asserting shutdown and fault during the amplifier-reset and ramp phases. In each case the behavioural model applies the priority order from the requirements, fault, then shutdown, then suspend, then phase expiry. It also ignores suspend during a cold start. Every output field is compared against the model on every clock, so a wrong winner shows up in the cycle where it happens.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_AMPRST = 3'd1,
    ST_RAMP   = 3'd2,
    ST_RUN    = 3'd3,
    ST_SUSP   = 3'd4,
    ST_RESUME = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    REQ_RUN  = 2'd0,
    REQ_SUSP = 2'd1,
    REQ_OFF  = 2'd2
  } sleep_req_e;

  function automatic sleep_req_e decode_req(input logic susp_n, input logic off_n);
    if (!off_n)       return REQ_OFF;
    else if (!susp_n) return REQ_SUSP;
    else              return REQ_RUN;
  endfunction
endpackage

// File: rtl/sync_bit.sv
module sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int PHASE_LEN = 2048,
  localparam int CNT_W    = $clog2(PHASE_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next,
  output logic             last
);
  assign cnt_next = restart ? '0 : cnt_q + 1'b1;
  assign last     = (cnt_q == CNT_W'(PHASE_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_next;
  end
endmodule

// File: rtl/ramp_scale.sv
module ramp_scale #(
  parameter int CNT_W  = 11,
  parameter int RAMP_W = 12
) (
  input  logic [CNT_W-1:0]  cnt,
  output logic [RAMP_W-1:0] code
);
  generate
    if (RAMP_W >= CNT_W) begin : g_widen
      assign code = {cnt, {(RAMP_W-CNT_W){1'b0}}};
    end else begin : g_narrow
      assign code = cnt[CNT_W-1 -: RAMP_W];
    end
  endgenerate
endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
  import sleep_seq_pkg::*;
#(
  parameter int PHASE_LEN   = 2048,
  parameter int RAMP_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slp_susp_n,
  input  logic              slp_off_n,
  input  logic              sby_por_ok,
  input  logic              v12_por_ok,
  input  logic              blk_trip_ok,
  input  logic              term_win_ok,
  input  logic              fault_off,
  output logic              core_en,
  output logic              sby_en,
  output logic              term_en,
  output logic              ref_short,
  output logic              blk_drive_low,
  output logic              amp_reset,
  output logic              ss_active,
  output logic [RAMP_W-1:0] ramp_code,
  output logic              pg_cmp_en,
  output logic              pwr_ok
);
  localparam int CNT_W = $clog2(PHASE_LEN);

  logic [1:0] raw_slp, syn_slp;
  assign raw_slp = {slp_off_n, slp_susp_n};

  generate
    for (genvar i = 0; i < 2; i++) begin : g_sync
      sync_bit #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw_slp[i]), .q(syn_slp[i])
      );
    end
  endgenerate

  sleep_req_e req;
  assign req = decode_req(syn_slp[0], syn_slp[1]);

  seq_state_e       state_q, state_d;
  logic             restart, phase_last;
  logic [CNT_W-1:0] cnt_q, cnt_next;
  logic [RAMP_W-1:0] ramp_scaled;

  assign restart = (state_d != state_q);

  phase_timer #(.PHASE_LEN(PHASE_LEN)) u_timer (
    .clk(clk), .rst(rst), .restart(restart),
    .cnt_q(cnt_q), .cnt_next(cnt_next), .last(phase_last)
  );

  ramp_scale #(.CNT_W(CNT_W), .RAMP_W(RAMP_W)) u_scale (
    .cnt(cnt_next), .code(ramp_scaled)
  );

  logic ready;
  assign ready = sby_por_ok && v12_por_ok && blk_trip_ok;

  always_comb begin
    state_d = state_q;
    if (fault_off || req == REQ_OFF) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:    if (req == REQ_RUN && ready) state_d = ST_AMPRST;
        ST_AMPRST: if (phase_last) state_d = ST_RAMP;
        ST_RAMP:   if (phase_last) state_d = ST_RUN;
        ST_RUN:    if (req == REQ_SUSP) state_d = ST_SUSP;
        ST_SUSP:   if (req == REQ_RUN && v12_por_ok) state_d = ST_RESUME;
        ST_RESUME: begin
          if (req == REQ_SUSP) state_d = ST_SUSP;
          else if (phase_last) state_d = ST_RUN;
        end
        default:   state_d = ST_OFF;
      endcase
    end
  end

  logic regs_on;
  assign regs_on = (state_d == ST_AMPRST) || (state_d == ST_RAMP) ||
                   (state_d == ST_RUN)    || (state_d == ST_RESUME);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_OFF;
      core_en       <= 1'b0;
      sby_en        <= 1'b0;
      term_en       <= 1'b0;
      ref_short     <= 1'b1;
      blk_drive_low <= 1'b1;
      amp_reset     <= 1'b0;
      ss_active     <= 1'b0;
      ramp_code     <= '0;
      pg_cmp_en     <= 1'b0;
      pwr_ok        <= 1'b0;
    end else begin
      state_q       <= state_d;
      core_en       <= regs_on;
      term_en       <= regs_on;
      ref_short     <= !regs_on;
      sby_en        <= (state_d == ST_SUSP);
      blk_drive_low <= (state_d == ST_OFF) || (state_d == ST_SUSP);
      amp_reset     <= (state_d == ST_AMPRST);
      ss_active     <= (state_d == ST_RAMP);
      pg_cmp_en     <= (state_d == ST_RUN);
      pwr_ok        <= (state_d == ST_RUN) && term_win_ok;
      unique case (state_d)
        ST_RAMP:                     ramp_code <= ramp_scaled;
        ST_RUN, ST_SUSP, ST_RESUME:  ramp_code <= '1;
        default:                     ramp_code <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sleep_seq_ctrl_chk.sv
module sleep_seq_ctrl_chk #(
  parameter int RAMP_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              fault_off,
  input logic              core_en,
  input logic              sby_en,
  input logic              term_en,
  input logic              ref_short,
  input logic              blk_drive_low,
  input logic              amp_reset,
  input logic              ss_active,
  input logic [RAMP_W-1:0] ramp_code,
  input logic              pg_cmp_en,
  input logic              pwr_ok
);
  // R6
  standby_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    sby_en |-> (!core_en && !term_en && !pwr_ok));

  // R11
  ref_short_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !term_en |-> ref_short);

  // R9
  pgood_needs_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_ok |-> pg_cmp_en);

  // R4
  amp_reset_phase_chk: assert property (@(posedge clk) disable iff (rst)
    amp_reset |-> (!ss_active && core_en && !blk_drive_low));

  // R8
  blk_low_no_pgood_chk: assert property (@(posedge clk) disable iff (rst)
    blk_drive_low |-> (!pwr_ok && !core_en));

  // R5
  ramp_rising_chk: assert property (@(posedge clk) disable iff (rst)
    (ss_active && $past(ss_active)) |-> (ramp_code > $past(ramp_code)));

  // R10
  fault_disables_chk: assert property (@(posedge clk) disable iff (rst)
    fault_off |=> (!core_en && !sby_en && !term_en && blk_drive_low));
endmodule

bind sleep_seq_ctrl sleep_seq_ctrl_chk #(.RAMP_W(RAMP_W)) u_chk (
  .clk(clk), .rst(rst), .fault_off(fault_off),
  .core_en(core_en), .sby_en(sby_en), .term_en(term_en),
  .ref_short(ref_short), .blk_drive_low(blk_drive_low),
  .amp_reset(amp_reset), .ss_active(ss_active), .ramp_code(ramp_code),
  .pg_cmp_en(pg_cmp_en), .pwr_ok(pwr_ok)
);

// File: tb/tb_sleep_seq_ctrl.sv
module tb_sleep_seq_ctrl;
  localparam int L      = 2048;
  localparam int RAMP_W = 12;
  localparam int FULL   = (1 << RAMP_W) - 1;
  // model state codes
  localparam int M_OFF = 0, M_AMP = 1, M_RAMP = 2, M_RUN = 3, M_SUSP = 4, M_RES = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slp_susp_n = 1'b0, slp_off_n = 1'b0;
  logic sby_por_ok = 1'b0, v12_por_ok = 1'b0, blk_trip_ok = 1'b0;
  logic term_win_ok = 1'b0, fault_off = 1'b0;
  logic core_en, sby_en, term_en, ref_short, blk_drive_low, amp_reset, ss_active;
  logic [RAMP_W-1:0] ramp_code;
  logic pg_cmp_en, pwr_ok;

  always #4 clk = ~clk;

  sleep_seq_ctrl #(.PHASE_LEN(L), .RAMP_W(RAMP_W)) dut (
    .clk(clk), .rst(rst), .slp_susp_n(slp_susp_n), .slp_off_n(slp_off_n),
    .sby_por_ok(sby_por_ok), .v12_por_ok(v12_por_ok), .blk_trip_ok(blk_trip_ok),
    .term_win_ok(term_win_ok), .fault_off(fault_off),
    .core_en(core_en), .sby_en(sby_en), .term_en(term_en), .ref_short(ref_short),
    .blk_drive_low(blk_drive_low), .amp_reset(amp_reset), .ss_active(ss_active),
    .ramp_code(ramp_code), .pg_cmp_en(pg_cmp_en), .pwr_ok(pwr_ok)
  );

  int vectors = 0, miscompares = 0, cyc = 0;
  bit win_toggle = 0, done = 0;

  // behavioural model
  int m_state = M_OFF, m_cnt = 0;
  bit m_s1a = 0, m_s2a = 0, m_s1b = 0, m_s2b = 0;
  int e_core, e_sby, e_term, e_ref, e_blk, e_amp, e_ss, e_ramp, e_cmp, e_pg;

  task automatic model_step();
    int ns;
    bit q_run, q_susp, q_off, on;
    if (rst) begin
      m_state = M_OFF; m_cnt = 0;
      m_s1a = 0; m_s2a = 0; m_s1b = 0; m_s2b = 0;
    end else begin
      q_off  = !m_s2b;                 // R1 decode
      q_susp = m_s2b && !m_s2a;
      q_run  = m_s2b && m_s2a;
      ns = m_state;
      if (fault_off || q_off) ns = M_OFF;      // R10, R8 priority
      else case (m_state)
        M_OFF:  if (q_run && sby_por_ok && v12_por_ok && blk_trip_ok) ns = M_AMP; // R3
        M_AMP:  if (m_cnt == L-1) ns = M_RAMP;   // R2: suspend ignored
        M_RAMP: if (m_cnt == L-1) ns = M_RUN;
        M_RUN:  if (q_susp) ns = M_SUSP;
        M_SUSP: if (q_run && v12_por_ok) ns = M_RES;
        M_RES:  if (q_susp) ns = M_SUSP; else if (m_cnt == L-1) ns = M_RUN;
        default: ns = M_OFF;
      endcase
      m_cnt = (ns != m_state) ? 0 : (m_cnt + 1) % L;
      m_state = ns;
      m_s2a = m_s1a; m_s1a = slp_susp_n;
      m_s2b = m_s1b; m_s1b = slp_off_n;
    end
    on = (m_state == M_AMP) || (m_state == M_RAMP) || (m_state == M_RUN) || (m_state == M_RES);
    e_core = on; e_term = on; e_ref = !on;
    e_sby  = (m_state == M_SUSP);
    e_blk  = (m_state == M_OFF) || (m_state == M_SUSP);
    e_amp  = (m_state == M_AMP);
    e_ss   = (m_state == M_RAMP);
    e_cmp  = (m_state == M_RUN);
    e_pg   = (!rst) && (m_state == M_RUN) && term_win_ok;
    if (m_state == M_RAMP) e_ramp = m_cnt * (1 << RAMP_W) / L;
    else if (m_state == M_RUN || m_state == M_SUSP || m_state == M_RES) e_ramp = FULL;
    else e_ramp = 0;
  endtask

  task automatic chk(string req, string nm, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, nm, cyc, act, exp);
    end
  endtask

  task automatic tick();
    cyc++;
    if (win_toggle) term_win_ok = ((cyc / 5) % 2) == 1;
    model_step();
    @(posedge clk);
    @(negedge clk);
    vectors++;
    chk("R7",  "core_en",       core_en,       e_core);
    chk("R6",  "sby_en",        sby_en,        e_sby);
    chk("R7",  "term_en",       term_en,       e_term);
    chk("R11", "ref_short",     ref_short,     e_ref);
    chk("R8",  "blk_drive_low", blk_drive_low, e_blk);
    chk("R4",  "amp_reset",     amp_reset,     e_amp);
    chk("R5",  "ss_active",     ss_active,     e_ss);
    chk("R5",  "ramp_code",     ramp_code,     e_ramp);
    chk("R7",  "pg_cmp_en",     pg_cmp_en,     e_cmp);
    chk("R9",  "pwr_ok",        pwr_ok,        e_pg);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic sleep_lv(bit susp_n, bit off_n);
    slp_susp_n = susp_n; slp_off_n = off_n;
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    run(4);                               // reset state
    rst = 0;
    sby_por_ok = 1; v12_por_ok = 1; blk_trip_ok = 1;
    sleep_lv(0, 1); run(30);              // R2: suspend after reset ignored
    sleep_lv(1, 1); v12_por_ok = 0; run(30);   // R3: 12V not ready
    v12_por_ok = 1; blk_trip_ok = 0; run(20);  // R3: trip not ready
    sby_por_ok = 0; blk_trip_ok = 1; run(20);  // R3: standby not ready
    win_toggle = 1;
    sby_por_ok = 1; run(100);             // R1 sync latency, R4 begins
    sleep_lv(0, 1); run(50);              // R2: suspend during cold start ignored
    sleep_lv(1, 1); run(4100);            // R4, R5, R9
    sleep_lv(0, 1); run(100);             // R6 suspend
    sleep_lv(1, 1); v12_por_ok = 0; run(50);   // R7 resume held by 12V
    v12_por_ok = 1; run(1000);
    sleep_lv(0, 1); run(50);              // R7 suspend during resume
    sleep_lv(1, 1); run(2100);
    for (int off = -2; off <= 2; off++) begin  // collision with resume expiry
      sleep_lv(0, 1); run(40);
      sleep_lv(1, 1); run(L + off);
      sleep_lv(0, 1); run(10);
      sleep_lv(1, 1); run(L + 10);
    end
    sleep_lv(0, 0); run(50);              // R8 shutdown with suspend low
    sleep_lv(0, 1); run(30);              // R2 after shutdown
    sleep_lv(1, 1); run(L + 1000);
    sleep_lv(1, 0); run(50);              // R8 shutdown in ramp, suspend high
    sleep_lv(1, 1); run(L - 2);
    sleep_lv(1, 0); run(20);              // R10 priority near phase end
    sleep_lv(1, 1); run(2 * L + 20);
    fault_off = 1; run(20);               // R10 fault in run
    fault_off = 0; run(2 * L + 20);
    sleep_lv(0, 1); run(30);
    fault_off = 1; run(10);               // R10 fault in suspend
    fault_off = 0; sleep_lv(1, 1); run(2 * L + 20);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule